// File: doc/BRIEF.md
# Timed Asynchronous SRAM Strobe Controller

This block sits between a synchronous host and a 16-bit asynchronous static RAM. The host hands over one request at a time through a valid/ready pair. Each request carries a word address, write data, a two-bit byte mask and a write flag. The controller turns the request into a strobe sequence on the memory pins that meets the memory's minimum timing.

Reads return their data on a one-cycle response pulse. Writes return nothing. Each phase length is derived from its own nanosecond figure: access, output-enable access, write pulse, data setup, enable-to-end-of-write and total cycle. Each figure becomes a whole clock count through a clock-period parameter. After every read a bus-turnaround gap gives the memory's output drivers time to release before the controller can drive the data bus again.

Between requests the memory is held selected but quiet: chip enables active, output enable and the write strobe both high, byte strobes off, data drivers off. The chip enables are tied active, because power-down sequencing is not part of this block.

Top module: `sram_strobe_ctrl`

## Requirements
- R1: After reset and between requests the pins are in this state: mem_ce1_n=0, mem_ce2=1, mem_oe_n=1, mem_we_n=1, mem_lb_n=1, mem_ub_n=1, mem_dq_oe=0. In this state req_ready=1.
- R2: A read with a nonzero mask holds mem_oe_n low and mem_addr stable for exactly RD_CYC consecutive cycles. RD_CYC is the larger of ceil(T_RC_NS/CLK_NS) and ceil(T_OE_NS/CLK_NS), and never less than 1. The data is sampled in the last of those cycles and shown on rsp_rdata, with rsp_valid high for one cycle, in the cycle after mem_oe_n rises.
- R3: Mask bit 0 selects the low lane: mem_dq bits [7:0] and mem_lb_n. Mask bit 1 selects the high lane: bits [15:8] and mem_ub_n. A lane strobe is driven low only during the strobe phase of a request whose mask bit is 1. A read returns zero in every unselected lane.
- R4: After a read, req_ready stays low for TA_CYC = ceil(T_HZ_NS/CLK_NS) cycles after mem_oe_n rises. mem_dq_oe cannot rise until at least TA_CYC+1 cycles after the last cycle in which mem_oe_n was low.
- R5: A write with a nonzero mask holds mem_we_n low for exactly WR_CYC consecutive cycles. WR_CYC is the largest of the counts for T_WP_NS, T_DW_NS and T_BW_NS. For the whole pulse, mem_dq_oe is high, mem_dq_out carries the write data and mem_addr is stable. mem_we_n and mem_dq_oe rise in the same cycle.
- R6: From one falling edge of mem_we_n to the next there are at least ceil(T_WC_NS/CLK_NS) cycles. Any shortfall after the pulse is spent in a recovery phase with req_ready low.
- R7: mem_oe_n stays high throughout every write, and mem_dq_oe is never high while mem_oe_n is low.
- R8: A request with mask 00 is accepted and produces no strobe on mem_oe_n, mem_we_n, mem_lb_n or mem_ub_n, and memory content is unchanged. A read with mask 00 returns rsp_valid in the next cycle with rsp_rdata zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | 2*LANE_W | Write data |
| req_be | input | 2 | Byte mask, bit 0 low lane, bit 1 high lane |
| rsp_valid | output | 1 | Read data valid pulse |
| rsp_rdata | output | 2*LANE_W | Read data, unselected lanes zero |
| mem_addr | output | ADDR_W | Memory address |
| mem_ce1_n | output | 1 | Active-low chip enable |
| mem_ce2 | output | 1 | Active-high chip enable |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_we_n | output | 1 | Read/write strobe, low writes |
| mem_lb_n | output | 1 | Active-low low-lane strobe |
| mem_ub_n | output | 1 | Active-low high-lane strobe |
| mem_dq_out | output | 2*LANE_W | Data toward the memory |
| mem_dq_oe | output | 1 | Data driver enable |
| mem_dq_in | input | 2*LANE_W | Data from the memory |

## Verification
A phase counter loaded with the wrong value, or a sequencer that leaves a phase early, shows at once as a strobe whose length is off. This bench counts those lengths sample by sample. A sequencer stuck in a state shows within one cycle as req_ready held low or as a strobe that never rises. Lane mapping faults appear in the first read after a partial write, as a wrong byte or a nonzero unselected lane. A missing turnaround shows in the first write that follows a read, as data drive beginning too soon after output enable rises.

// File: rtl/sram_strobe_pkg.sv
package sram_strobe_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_READ  = 3'd1,
    ST_TURN  = 3'd2,
    ST_WRITE = 3'd3,
    ST_RECOV = 3'd4
  } seq_state_t;

  // Whole clocks covering a nanosecond minimum, never fewer than one.
  function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned clk_ns);
    int unsigned c;
    c = (ns + clk_ns - 1) / clk_ns;
    return (c == 0) ? 1 : c;
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sst_phase_timer.sv
module sst_phase_timer #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             done
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = load || (cnt_q != '0);
    if (load) begin
      cnt_d = load_val;
    end else begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign done = (cnt_q == '0);

endmodule

// File: rtl/sst_seq.sv
module sst_seq
  import sram_strobe_pkg::*;
#(
  parameter int unsigned RD_CYC  = 6,
  parameter int unsigned TA_CYC  = 3,
  parameter int unsigned WR_CYC  = 5,
  parameter int unsigned REC_CYC = 1,
  parameter int unsigned CNT_W   = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic             mask_zero,
  input  logic             timer_done,
  output seq_state_t       state,
  output logic             req_ready,
  output logic             accept,
  output logic             timer_load,
  output logic [CNT_W-1:0] timer_val,
  output logic             capture,
  output logic             zero_rsp
);

  localparam logic [CNT_W-1:0] RD_LD  = CNT_W'(RD_CYC - 1);
  localparam logic [CNT_W-1:0] TA_LD  = CNT_W'(TA_CYC - 1);
  localparam logic [CNT_W-1:0] WR_LD  = CNT_W'(WR_CYC - 1);
  localparam bit               HAS_REC = (REC_CYC > 0);
  localparam logic [CNT_W-1:0] REC_LD = HAS_REC ? CNT_W'(REC_CYC - 1) : '0;

  seq_state_t state_q;
  seq_state_t state_d;

  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign state     = state_q;

  always_comb begin
    state_d    = state_q;
    timer_load = 1'b0;
    timer_val  = '0;
    capture    = 1'b0;
    zero_rsp   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (accept) begin
          if (mask_zero) begin
            zero_rsp = !req_write;
          end else if (req_write) begin
            state_d    = ST_WRITE;
            timer_load = 1'b1;
            timer_val  = WR_LD;
          end else begin
            state_d    = ST_READ;
            timer_load = 1'b1;
            timer_val  = RD_LD;
          end
        end
      end
      ST_READ: begin
        if (timer_done) begin
          capture    = 1'b1;
          state_d    = ST_TURN;
          timer_load = 1'b1;
          timer_val  = TA_LD;
        end
      end
      ST_TURN: begin
        if (timer_done) begin
          state_d = ST_IDLE;
        end
      end
      ST_WRITE: begin
        if (timer_done) begin
          if (HAS_REC) begin
            state_d    = ST_RECOV;
            timer_load = 1'b1;
            timer_val  = REC_LD;
          end else begin
            state_d = ST_IDLE;
          end
        end
      end
      ST_RECOV: begin
        if (timer_done) begin
          state_d = ST_IDLE;
        end
      end
      default: begin
        state_d = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  AST_PHASE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE && !timer_done) |=> (state_q == $past(state_q))); // R2

  AST_TURN_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_TURN && !timer_done) |=> !req_ready); // R4

endmodule

// File: rtl/sst_datapath.sv
module sst_datapath #(
  parameter int unsigned ADDR_W = 20,
  parameter int unsigned LANE_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  accept,
  input  logic [ADDR_W-1:0]     req_addr,
  input  logic [2*LANE_W-1:0]   req_wdata,
  input  logic [1:0]            req_be,
  input  logic                  strobe,
  input  logic                  capture,
  input  logic                  zero_rsp,
  input  logic [2*LANE_W-1:0]   mem_dq_in,
  output logic                  mask_zero,
  output logic [ADDR_W-1:0]     addr_q,
  output logic [2*LANE_W-1:0]   wdata_q,
  output logic [1:0]            lane_n,
  output logic                  rsp_valid,
  output logic [2*LANE_W-1:0]   rsp_rdata
);

  localparam int unsigned DATA_W = 2 * LANE_W;

  logic [1:0]        be_q;
  logic [DATA_W-1:0] rd_masked;
  logic [DATA_W-1:0] rdata_d;
  logic              rdata_en;
  logic              rsp_d;

  assign mask_zero = (req_be == 2'b00);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      be_q    <= '0;
    end else if (accept) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
      be_q    <= req_be;
    end
  end

  for (genvar i = 0; i < 2; i++) begin : g_lane
    assign lane_n[i] = !(strobe && be_q[i]);
    assign rd_masked[i*LANE_W +: LANE_W] = be_q[i] ? mem_dq_in[i*LANE_W +: LANE_W] : '0;
  end

  always_comb begin
    rdata_en = capture || zero_rsp;
    rdata_d  = capture ? rd_masked : '0;
    rsp_d    = capture || zero_rsp;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_rdata <= '0;
    end else if (rdata_en) begin
      rsp_rdata <= rdata_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
    end else begin
      rsp_valid <= rsp_d;
    end
  end

  AST_LANE_IDLE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe |-> (lane_n == 2'b11)); // R3

endmodule

// File: rtl/sram_strobe_ctrl.sv
module sram_strobe_ctrl
  import sram_strobe_pkg::*;
#(
  parameter int unsigned ADDR_W  = 20,
  parameter int unsigned LANE_W  = 8,
  parameter int unsigned CLK_NS  = 10,
  parameter int unsigned T_RC_NS = 55,
  parameter int unsigned T_OE_NS = 30,
  parameter int unsigned T_HZ_NS = 25,
  parameter int unsigned T_WP_NS = 45,
  parameter int unsigned T_DW_NS = 25,
  parameter int unsigned T_BW_NS = 50,
  parameter int unsigned T_WC_NS = 55
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic                req_write,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [2*LANE_W-1:0] req_wdata,
  input  logic [1:0]          req_be,
  output logic                rsp_valid,
  output logic [2*LANE_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic                mem_ce1_n,
  output logic                mem_ce2,
  output logic                mem_oe_n,
  output logic                mem_we_n,
  output logic                mem_lb_n,
  output logic                mem_ub_n,
  output logic [2*LANE_W-1:0] mem_dq_out,
  output logic                mem_dq_oe,
  input  logic [2*LANE_W-1:0] mem_dq_in
);

  localparam int unsigned RD_CYC  = max2(ns_to_cyc(T_RC_NS, CLK_NS), ns_to_cyc(T_OE_NS, CLK_NS));
  localparam int unsigned TA_CYC  = ns_to_cyc(T_HZ_NS, CLK_NS);
  localparam int unsigned WR_CYC  = max2(max2(ns_to_cyc(T_WP_NS, CLK_NS), ns_to_cyc(T_DW_NS, CLK_NS)),
                                         ns_to_cyc(T_BW_NS, CLK_NS));
  localparam int unsigned WC_CYC  = ns_to_cyc(T_WC_NS, CLK_NS);
  localparam int unsigned REC_CYC = (WC_CYC > WR_CYC) ? (WC_CYC - WR_CYC) : 0;
  localparam int unsigned MAX_CYC = max2(max2(RD_CYC, TA_CYC), max2(WR_CYC, REC_CYC));
  localparam int unsigned CNT_W   = $clog2(MAX_CYC + 1);
  localparam int unsigned MON_W   = CNT_W + 1;

  seq_state_t       state;
  logic             accept;
  logic             timer_load;
  logic [CNT_W-1:0] timer_val;
  logic             timer_done;
  logic             capture;
  logic             zero_rsp;
  logic             mask_zero;
  logic             in_read;
  logic             in_write;
  logic [1:0]       lane_n;

  sst_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (timer_load),
    .load_val (timer_val),
    .done     (timer_done)
  );

  sst_seq #(
    .RD_CYC  (RD_CYC),
    .TA_CYC  (TA_CYC),
    .WR_CYC  (WR_CYC),
    .REC_CYC (REC_CYC),
    .CNT_W   (CNT_W)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .mask_zero  (mask_zero),
    .timer_done (timer_done),
    .state      (state),
    .req_ready  (req_ready),
    .accept     (accept),
    .timer_load (timer_load),
    .timer_val  (timer_val),
    .capture    (capture),
    .zero_rsp   (zero_rsp)
  );

  assign in_read  = (state == ST_READ);
  assign in_write = (state == ST_WRITE);

  sst_datapath #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .req_be    (req_be),
    .strobe    (in_read || in_write),
    .capture   (capture),
    .zero_rsp  (zero_rsp),
    .mem_dq_in (mem_dq_in),
    .mask_zero (mask_zero),
    .addr_q    (mem_addr),
    .wdata_q   (mem_dq_out),
    .lane_n    (lane_n),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata)
  );

  assign mem_ce1_n = 1'b0;
  assign mem_ce2   = 1'b1;
  assign mem_oe_n  = !in_read;
  assign mem_we_n  = !in_write;
  assign mem_dq_oe = in_write;
  assign mem_lb_n  = lane_n[0];
  assign mem_ub_n  = lane_n[1];

  // Run-length monitors for the timing assertions below.
  localparam logic [MON_W-1:0] MON_MAX = '1;
  logic [MON_W-1:0] oe_low_run;
  logic [MON_W-1:0] we_low_run;
  logic [MON_W-1:0] oe_high_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oe_low_run  <= '0;
      we_low_run  <= '0;
      oe_high_run <= MON_MAX;
    end else begin
      oe_low_run  <= !mem_oe_n ? ((oe_low_run == MON_MAX) ? MON_MAX : oe_low_run + 1'b1) : '0;
      we_low_run  <= !mem_we_n ? ((we_low_run == MON_MAX) ? MON_MAX : we_low_run + 1'b1) : '0;
      oe_high_run <= mem_oe_n ? ((oe_high_run == MON_MAX) ? MON_MAX : oe_high_run + 1'b1) : '0;
    end
  end

  AST_READ_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_oe_n) |-> (oe_low_run == MON_W'(RD_CYC))); // R2

  AST_WRITE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (we_low_run == MON_W'(WR_CYC))); // R5

  AST_WRITE_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_we_n && !$past(mem_we_n)) |-> $stable(mem_addr) && $stable(mem_dq_out)); // R5

  AST_DRIVE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_dq_oe) |-> (oe_high_run > MON_W'(TA_CYC))); // R4

  AST_OE_HIGH_IN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> mem_oe_n); // R7

  AST_RSP_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !$past(zero_rsp)) |-> $rose(mem_oe_n) || $past(capture)); // R2

endmodule

// File: tb/sram_strobe_ctrl_tb.sv
module sram_strobe_ctrl_tb;

  localparam int CLK_NS = 8;
  localparam int AW     = 20;
  localparam int DW     = 16;

  function automatic int cdiv(input int ns);
    int c;
    c = (ns + CLK_NS - 1) / CLK_NS;
    return (c < 1) ? 1 : c;
  endfunction

  localparam int EXP_RD = (cdiv(55) > cdiv(30)) ? cdiv(55) : cdiv(30);
  localparam int EXP_TA = cdiv(25);
  localparam int EXP_WR0 = (cdiv(45) > cdiv(25)) ? cdiv(45) : cdiv(25);
  localparam int EXP_WR = (EXP_WR0 > cdiv(50)) ? EXP_WR0 : cdiv(50);
  localparam int EXP_WC = cdiv(55);
  localparam int EXP_REC = (EXP_WC > EXP_WR) ? EXP_WC - EXP_WR : 0;

  logic          clk;
  logic          rst_n;
  logic          req_valid;
  logic          req_ready;
  logic          req_write;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_wdata;
  logic [1:0]    req_be;
  logic          rsp_valid;
  logic [DW-1:0] rsp_rdata;
  logic [AW-1:0] mem_addr;
  logic          mem_ce1_n;
  logic          mem_ce2;
  logic          mem_oe_n;
  logic          mem_we_n;
  logic          mem_lb_n;
  logic          mem_ub_n;
  logic [DW-1:0] mem_dq_out;
  logic          mem_dq_oe;
  logic [DW-1:0] mem_dq_in;

  int n_chk;
  int n_err;
  bit finished;

  sram_strobe_ctrl #(.ADDR_W(AW), .LANE_W(8), .CLK_NS(CLK_NS)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
    .mem_ce1_n(mem_ce1_n), .mem_ce2(mem_ce2), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_lb_n(mem_lb_n), .mem_ub_n(mem_ub_n), .mem_dq_out(mem_dq_out),
    .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
  );

  initial clk = 1'b0;
  always #4 clk = !clk;

  // Behavioural memory: 16 words, lanes written while strobes are low.
  logic [DW-1:0] model_q [0:15];
  initial begin
    for (int i = 0; i < 16; i++) model_q[i] = '0;
  end
  always @(posedge clk) begin
    if (!mem_we_n && !mem_ce1_n && mem_ce2) begin
      if (!mem_lb_n) model_q[mem_addr[3:0]][7:0]  <= mem_dq_out[7:0];
      if (!mem_ub_n) model_q[mem_addr[3:0]][15:8] <= mem_dq_out[15:8];
    end
  end
  assign mem_dq_in = (!mem_oe_n && !mem_ce1_n && mem_ce2) ? model_q[mem_addr[3:0]] : 16'hBEEF;

  // Global bus monitor, sampled at the falling edge.
  int cyc;
  int last_oe_low;
  int last_we_fall;
  bit prev_dq_oe;
  bit prev_we_n;
  int gap_err;
  int wc_err;
  int ovl_err;
  initial begin
    cyc = 0; last_oe_low = -1000; last_we_fall = -1000;
    prev_dq_oe = 0; prev_we_n = 1; gap_err = 0; wc_err = 0; ovl_err = 0;
  end
  always @(negedge clk) begin
    if (rst_n) begin
      cyc++;
      if (mem_dq_oe && !prev_dq_oe && (cyc - last_oe_low) <= EXP_TA) gap_err++;
      if (!mem_oe_n) last_oe_low = cyc;
      if (!mem_we_n && prev_we_n) begin
        if ((cyc - last_we_fall) < EXP_WC) wc_err++;
        last_we_fall = cyc;
      end
      if (mem_dq_oe && !mem_oe_n) ovl_err++;
      prev_dq_oe = mem_dq_oe;
      prev_we_n  = mem_we_n;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Per-request observations.
  int r_oe, r_we, r_busy, r_rsp, r_drv_bad, r_lane_bad, r_oe_in_wr, r_addr_bad;
  logic [DW-1:0] r_data;

  task automatic run_req(input logic wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                         input logic [1:0] be);
    r_oe = 0; r_we = 0; r_busy = 0; r_rsp = 0; r_drv_bad = 0;
    r_lane_bad = 0; r_oe_in_wr = 0; r_addr_bad = 0; r_data = '0;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_be = be;
    @(negedge clk);
    req_valid = 1'b0;
    for (int k = 0; k < 60; k++) begin
      if (!mem_oe_n) r_oe++;
      if (!mem_we_n) r_we++;
      if (!req_ready) r_busy++;
      if (rsp_valid) begin r_rsp++; r_data = rsp_rdata; end
      if (!mem_we_n && (!mem_dq_oe || mem_dq_out !== d)) r_drv_bad++;
      if (mem_we_n && mem_dq_oe) r_drv_bad++;
      if (wr && !mem_oe_n) r_oe_in_wr++;
      if (!mem_oe_n || !mem_we_n) begin
        if (mem_lb_n !== !be[0] || mem_ub_n !== !be[1]) r_lane_bad++;
        if (mem_addr !== a) r_addr_bad++;
      end else if (!mem_lb_n || !mem_ub_n) begin
        r_lane_bad++;
      end
      if (req_ready) break;
      @(negedge clk);
    end
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R1 req_ready", req_ready, 1);
    chk("R1 ce", {mem_ce1_n, mem_ce2}, 2'b01);
    chk("R1 oe/we", {mem_oe_n, mem_we_n}, 2'b11);
    chk("R1 lanes", {mem_ub_n, mem_lb_n}, 2'b11);
    chk("R1 dq_oe", mem_dq_oe, 0);
    chk("R1 rsp_valid", rsp_valid, 0);
  endtask

  task automatic t_write_full;
    run_req(1'b1, 20'h00003, 16'hA55A, 2'b11);
    chk("R5 we low cycles", r_we, EXP_WR);
    chk("R5 drive/data during pulse", r_drv_bad, 0);
    chk("R5 address held", r_addr_bad, 0);
    chk("R6 busy cycles", r_busy, EXP_WR + EXP_REC);
    chk("R7 oe high in write", r_oe_in_wr, 0);
    chk("R3 lane strobes write", r_lane_bad, 0);
  endtask

  task automatic t_read_full;
    run_req(1'b0, 20'h00003, 16'h0000, 2'b11);
    chk("R2 oe low cycles", r_oe, EXP_RD);
    chk("R2 one response", r_rsp, 1);
    chk("R2 read data", r_data, 16'hA55A);
    chk("R4 busy incl turnaround", r_busy, EXP_RD + EXP_TA);
    chk("R2 address held", r_addr_bad, 0);
  endtask

  task automatic t_lanes;
    run_req(1'b1, 20'h00003, 16'h1234, 2'b01);
    chk("R3 low-lane write strobes", r_lane_bad, 0);
    run_req(1'b0, 20'h00003, 16'h0000, 2'b10);
    chk("R3 high lane only", r_data, 16'hA500);
    chk("R3 read strobes high", r_lane_bad, 0);
    run_req(1'b0, 20'h00003, 16'h0000, 2'b01);
    chk("R3 low lane only", r_data, 16'h0034);
    run_req(1'b1, 20'h00005, 16'h77CC, 2'b10);
    run_req(1'b0, 20'h00005, 16'h0000, 2'b11);
    chk("R3 high lane write", r_data, 16'h7700);
  endtask

  task automatic t_zero_mask;
    run_req(1'b1, 20'h00003, 16'hFFFF, 2'b00);
    chk("R8 no we strobe", r_we, 0);
    chk("R8 no busy", r_busy, 0);
    chk("R8 no lane strobe", r_lane_bad, 0);
    run_req(1'b0, 20'h00003, 16'h0000, 2'b00);
    chk("R8 no oe strobe", r_oe, 0);
    chk("R8 zero read response", r_rsp, 1);
    chk("R8 zero read data", r_data, 16'h0000);
    run_req(1'b0, 20'h00003, 16'h0000, 2'b11);
    chk("R8 memory unchanged", r_data, 16'hA534);
  endtask

  task automatic t_turnaround;
    run_req(1'b0, 20'h00003, 16'h0000, 2'b11);
    run_req(1'b1, 20'h00007, 16'h5AA5, 2'b11);
    run_req(1'b1, 20'h00008, 16'h0F0F, 2'b11);
    run_req(1'b1, 20'h00009, 16'hF0F0, 2'b11);
    run_req(1'b0, 20'h00007, 16'h0000, 2'b11);
    chk("R4 read-to-write gap", gap_err, 0);
    chk("R6 write spacing", wc_err, 0);
    chk("R7 no drive under oe", ovl_err, 0);
    chk("R5 back-to-back write data", r_data, 16'h5AA5);
  endtask

  task automatic finish_run;
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_run();
    end
  end

  initial begin
    n_chk = 0; n_err = 0; finished = 0;
    req_valid = 0; req_write = 0; req_addr = '0; req_wdata = '0; req_be = '0;
    rst_n = 0;
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1;
    repeat (2) @(posedge clk);
    t_reset();
    t_write_full();
    t_read_full();
    t_lanes();
    t_zero_mask();
    t_turnaround();
    t_reset();
    finished = 1;
    finish_run();
  end

endmodule